// File: doc/BRIEF.md
# Amplifier Power State Sequencer

This block decides which power state an audio amplifier core is in. Three things drive it: a hardware reset pad, a software enable bit and a one-cycle software-reset strobe. It moves through six states. These are hardware shutdown, initialisation (the control bus is not yet usable), software shutdown (idle, control bus ready), power-up, active and power-down. It tells the rest of the chip when the control bus may be used, when the amplifier is running, and when a power-down has finished.

Every wait is counted in clock cycles. The count is a time in microseconds multiplied by the `CLKS_PER_US` parameter. The length of a power-up or power-down wait is set by two inputs, the volume-ramp enable and the low-sample-rate flag (rate below 44.1 kHz). Both are taken at the moment the wait begins. A glitch filter sits after a two-flop synchronizer and keeps short pulses on the reset pad from shutting the device down.

Top module: `psq_power_seq`

## Requirements
- R1: While `rst_n` is low and on release with the pad held low, `state_o` is 0 (hardware shutdown), and `ctrl_ready`, `amp_active` and `pdn_done` are all 0.
- R2: The pad is sampled by a two-flop synchronizer. A low that lasts fewer than `RST_MIN_US*CLKS_PER_US` synchronized cycles is ignored. A low of at least that length forces state 0 from any state.
- R3: When the pad is high and no shutdown is requested, state 0 moves to initialisation (`state_o`=1). State 1 lasts exactly `T_BOOT_US*CLKS_PER_US` cycles and is followed by software shutdown (`state_o`=2) with `ctrl_ready`=1.
- R4: A `sw_reset` pulse in any state other than 0 enters state 1 for exactly `T_SWRST_US*CLKS_PER_US` cycles, then state 2, and clears `pdn_done`.
- R5: In state 2, `sw_en`=1 enters power-up (`state_o`=3). State 3 lasts `T_UP_US`, `T_UP_RAMP_US`, `T_UP_SLOW_US` or `T_UP_SLOW_RAMP_US` times `CLKS_PER_US` cycles for (ramp, low rate) = (0,0), (1,0), (0,1) and (1,1). It is followed by active (`state_o`=4).
- R6: Clearing `sw_en` in state 4 enters power-down (`state_o`=5). State 5 lasts `T_DN_US*CLKS_PER_US` cycles with ramp off, at either rate. With ramp on it lasts `T_DN_RAMP_US*CLKS_PER_US` cycles, or `T_DN_SLOW_RAMP_US*CLKS_PER_US` cycles at low rate. It then returns to state 2.
- R7: `ramp_en` and `rate_low` are taken only when a power-up or power-down wait begins. Changing them during the wait does not change its length.
- R8: `pdn_done` goes to 1 on the cycle that state 5 ends and holds until the next entry into state 3, a software reset, or a hardware shutdown.
- R9: Clearing `sw_en` during state 3 moves to state 5 on the next clock, without finishing the power-up wait.
- R10: Setting `sw_en` again during state 5 does not shorten it. Power-down runs its full length before any new power-up.
- R11: `ctrl_ready` is 1 exactly in states 2 to 5. `amp_active` is 1 exactly in state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer logic |
| pad_rst_n | input | 1 | Asynchronous hardware reset pad, active low |
| sw_en | input | 1 | Software enable: 1 requests active, 0 requests software shutdown |
| sw_reset | input | 1 | One-cycle software reset strobe |
| ramp_en | input | 1 | Volume ramp enabled; lengthens power-up and power-down |
| rate_low | input | 1 | Sample rate below 44.1 kHz |
| state_o | output | 3 | Current state code (0 to 5, as in the requirements) |
| ctrl_ready | output | 1 | Control bus may be used |
| amp_active | output | 1 | Amplifier in active state |
| pdn_done | output | 1 | Last power-down has completed |

## Verification
Power-up is run under all four combinations of ramp enable and rate class. Each combination gives a distinct dwell, so a swapped selector or a missing multiplier shows up as a wrong cycle count. Power-down is run at no ramp, at both rates, and with ramp at both rates, which separates a rate input that should be ignored from one that must matter. Reset-pad pulses one cycle shorter than the minimum and exactly at the minimum locate the filter boundary. Flipping the mode inputs mid-wait, dropping the enable mid power-up, and raising it mid power-down show whether the modes are latched at entry and whether the abort and no-shortcut rules hold.

// File: rtl/psq_pkg.sv
// Package: shared state and wait-selector types for the power sequencer.
// Assumes: state codes are visible at the top-level output and must stay fixed.
package psq_pkg;

    typedef enum logic [2:0] {
        ST_HWOFF  = 3'd0,
        ST_INIT   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_RAMPUP = 3'd3,
        ST_RUN    = 3'd4,
        ST_RAMPDN = 3'd5
    } psq_state_e;

    typedef enum logic [1:0] {
        WAIT_BOOT  = 2'd0,
        WAIT_SWRST = 2'd1,
        WAIT_UP    = 2'd2,
        WAIT_DOWN  = 2'd3
    } psq_wait_e;

    function automatic int unsigned psq_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psq_pin_filter.sv
// Module: psq_pin_filter
// Synchronizes the asynchronous reset pad and reports a shutdown request only
// after the synchronized pad has stayed low for MIN_LOW_CYC consecutive cycles.
// Assumes: SYNC_STAGES >= 2, MIN_LOW_CYC >= 1.
module psq_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_n,
    output logic hw_off
);
    localparam int unsigned LW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [LW-1:0] LIM = LW'(MIN_LOW_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [LW-1:0]          low_cnt;
    logic                   synced_n;

    // Synchronizer chain; reset value treats the pad as held low.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                // First stage samples the pad.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pad_n;
                end
            end else begin : g_next
                // Later stages shift the sampled value.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign synced_n = sync_q[SYNC_STAGES-1];

    // Counts consecutive low samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= LIM;
        else if (synced_n)     low_cnt <= '0;
        else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign hw_off = (low_cnt == LIM);

    // R2
    pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_off) |-> !$past(synced_n));

endmodule

// File: rtl/psq_delay_sel.sv
// Module: psq_delay_sel
// Picks the preset for the wait timer from the wait kind, the ramp enable and
// the sample-rate class. Presets are cycle counts minus one.
// Assumes: every time parameter times CLKS_PER_US fits in CNT_W bits.
module psq_delay_sel
    import psq_pkg::*;
#(
    parameter int unsigned CLKS_PER_US       = 100,
    parameter int unsigned CNT_W             = 20,
    parameter int unsigned T_BOOT_US         = 1500,
    parameter int unsigned T_SWRST_US        = 400,
    parameter int unsigned T_UP_US           = 1000,
    parameter int unsigned T_UP_RAMP_US      = 2700,
    parameter int unsigned T_UP_SLOW_US      = 2300,
    parameter int unsigned T_UP_SLOW_RAMP_US = 4200,
    parameter int unsigned T_DN_US           = 100,
    parameter int unsigned T_DN_RAMP_US      = 4600,
    parameter int unsigned T_DN_SLOW_RAMP_US = 8000
) (
    input  psq_wait_e          wsel,
    input  logic               ramp_en,
    input  logic               rate_low,
    output logic [CNT_W-1:0]   preset
);
    localparam logic [CNT_W-1:0] P_BOOT  = CNT_W'(T_BOOT_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_SWRST = CNT_W'(T_SWRST_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_UP    = CNT_W'(T_UP_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_UPR   = CNT_W'(T_UP_RAMP_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_UPS   = CNT_W'(T_UP_SLOW_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_UPSR  = CNT_W'(T_UP_SLOW_RAMP_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_DN    = CNT_W'(T_DN_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_DNR   = CNT_W'(T_DN_RAMP_US * CLKS_PER_US - 1);
    localparam logic [CNT_W-1:0] P_DNSR  = CNT_W'(T_DN_SLOW_RAMP_US * CLKS_PER_US - 1);

    // Selects the preset; the rate class matters for power-down only with ramp.
    always_comb begin
        preset = P_BOOT;
        unique case (wsel)
            WAIT_BOOT:  preset = P_BOOT;
            WAIT_SWRST: preset = P_SWRST;
            WAIT_UP: begin
                case ({ramp_en, rate_low})
                    2'b00:   preset = P_UP;
                    2'b10:   preset = P_UPR;
                    2'b01:   preset = P_UPS;
                    default: preset = P_UPSR;
                endcase
            end
            WAIT_DOWN: begin
                if (!ramp_en)      preset = P_DN;
                else if (rate_low) preset = P_DNSR;
                else               preset = P_DNR;
            end
            default: preset = P_BOOT;
        endcase
    end

endmodule

// File: rtl/psq_timer.sv
// Module: psq_timer
// Down-counter for state dwell times: loads a preset, counts to zero and
// reports expiry while at zero. A load of N-1 gives a dwell of N cycles.
// Assumes: the owner ignores expired outside waiting states.
module psq_timer #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Loads on request, otherwise decrements until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= preset;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R5
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(preset)));

endmodule

// File: rtl/psq_power_seq.sv
// Module: psq_power_seq (top)
// Power state sequencer: hardware shutdown, initialisation, software shutdown,
// power-up, active and power-down, with dwell times scaled by CLKS_PER_US.
// Priority: hardware shutdown over software reset over normal sequencing.
// Assumes: sw_reset is a single-cycle strobe; rst_n is synchronous to clk.
module psq_power_seq
    import psq_pkg::*;
#(
    parameter int unsigned CLKS_PER_US       = 100,
    parameter int unsigned SYNC_STAGES       = 2,
    parameter int unsigned RST_MIN_US        = 1,
    parameter int unsigned T_BOOT_US         = 1500,
    parameter int unsigned T_SWRST_US        = 400,
    parameter int unsigned T_UP_US           = 1000,
    parameter int unsigned T_UP_RAMP_US      = 2700,
    parameter int unsigned T_UP_SLOW_US      = 2300,
    parameter int unsigned T_UP_SLOW_RAMP_US = 4200,
    parameter int unsigned T_DN_US           = 100,
    parameter int unsigned T_DN_RAMP_US      = 4600,
    parameter int unsigned T_DN_SLOW_RAMP_US = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_rst_n,
    input  logic       sw_en,
    input  logic       sw_reset,
    input  logic       ramp_en,
    input  logic       rate_low,
    output logic [2:0] state_o,
    output logic       ctrl_ready,
    output logic       amp_active,
    output logic       pdn_done
);
    localparam int unsigned MAX_US =
        psq_max(psq_max(psq_max(T_BOOT_US, T_SWRST_US), psq_max(T_UP_US, T_UP_RAMP_US)),
                psq_max(psq_max(T_UP_SLOW_US, T_UP_SLOW_RAMP_US),
                        psq_max(T_DN_US, psq_max(T_DN_RAMP_US, T_DN_SLOW_RAMP_US))));
    localparam int unsigned MAX_CYC   = MAX_US * CLKS_PER_US;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam int unsigned MIN_LOW   = RST_MIN_US * CLKS_PER_US;

    psq_state_e       st, st_nxt;
    psq_wait_e        wsel;
    logic             load, expired, hw_off, pdn_set, pdn_clr;
    logic [CNT_W-1:0] preset;

    psq_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW_CYC (MIN_LOW)
    ) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_n  (pad_rst_n),
        .hw_off (hw_off)
    );

    psq_delay_sel #(
        .CLKS_PER_US       (CLKS_PER_US),
        .CNT_W             (CNT_W),
        .T_BOOT_US         (T_BOOT_US),
        .T_SWRST_US        (T_SWRST_US),
        .T_UP_US           (T_UP_US),
        .T_UP_RAMP_US      (T_UP_RAMP_US),
        .T_UP_SLOW_US      (T_UP_SLOW_US),
        .T_UP_SLOW_RAMP_US (T_UP_SLOW_RAMP_US),
        .T_DN_US           (T_DN_US),
        .T_DN_RAMP_US      (T_DN_RAMP_US),
        .T_DN_SLOW_RAMP_US (T_DN_SLOW_RAMP_US)
    ) u_sel (
        .wsel     (wsel),
        .ramp_en  (ramp_en),
        .rate_low (rate_low),
        .preset   (preset)
    );

    psq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .preset  (preset),
        .expired (expired)
    );

    // Next-state decode with timer load and done-flag controls.
    always_comb begin
        st_nxt  = st;
        load    = 1'b0;
        wsel    = WAIT_BOOT;
        pdn_set = 1'b0;
        pdn_clr = 1'b0;
        if (hw_off) begin
            st_nxt = ST_HWOFF;
        end else if (sw_reset && st != ST_HWOFF) begin
            st_nxt  = ST_INIT;
            load    = 1'b1;
            wsel    = WAIT_SWRST;
            pdn_clr = 1'b1;
        end else begin
            case (st)
                ST_HWOFF: begin
                    st_nxt = ST_INIT;
                    load   = 1'b1;
                    wsel   = WAIT_BOOT;
                end
                ST_INIT: begin
                    if (expired) st_nxt = ST_IDLE;
                end
                ST_IDLE: begin
                    if (sw_en) begin
                        st_nxt  = ST_RAMPUP;
                        load    = 1'b1;
                        wsel    = WAIT_UP;
                        pdn_clr = 1'b1;
                    end
                end
                ST_RAMPUP: begin
                    if (!sw_en) begin
                        st_nxt = ST_RAMPDN;
                        load   = 1'b1;
                        wsel   = WAIT_DOWN;
                    end else if (expired) begin
                        st_nxt = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!sw_en) begin
                        st_nxt = ST_RAMPDN;
                        load   = 1'b1;
                        wsel   = WAIT_DOWN;
                    end
                end
                ST_RAMPDN: begin
                    if (expired) begin
                        st_nxt  = ST_IDLE;
                        pdn_set = 1'b1;
                    end
                end
                default: st_nxt = ST_HWOFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HWOFF;
        else        st <= st_nxt;
    end

    // Power-down-done flag: set on completion, cleared by enable or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pdn_done <= 1'b0;
        else if (hw_off || pdn_clr) pdn_done <= 1'b0;
        else if (pdn_set)           pdn_done <= 1'b1;
    end

    assign state_o    = st;
    assign ctrl_ready = (st == ST_IDLE) || (st == ST_RAMPUP) ||
                        (st == ST_RUN)  || (st == ST_RAMPDN);
    assign amp_active = (st == ST_RUN);

    // R2
    hw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_off |=> (st == ST_HWOFF));

    // R8
    pdn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdn_done) |-> ($past(st) == ST_RAMPDN));

    // R5
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> ($past(st) == ST_RAMPUP || $past(st) == ST_RUN));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMPUP && !sw_en && !hw_off && !sw_reset) |=> (st == ST_RAMPDN));

    // R10
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMPDN && !expired && !hw_off && !sw_reset) |=> (st == ST_RAMPDN));

endmodule

// File: tb/tb_psq_power_seq.sv
// Directed bench for psq_power_seq with CLKS_PER_US = 2.
module tb_psq_power_seq;
    localparam int K = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_rst_n = 1'b0;
    logic       sw_en = 1'b0;
    logic       sw_reset = 1'b0;
    logic       ramp_en = 1'b0;
    logic       rate_low = 1'b0;
    logic [2:0] state_o;
    logic       ctrl_ready, amp_active, pdn_done;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    psq_power_seq #(.CLKS_PER_US(K)) dut (
        .clk(clk), .rst_n(rst_n), .pad_rst_n(pad_rst_n), .sw_en(sw_en),
        .sw_reset(sw_reset), .ramp_en(ramp_en), .rate_low(rate_low),
        .state_o(state_o), .ctrl_ready(ctrl_ready), .amp_active(amp_active),
        .pdn_done(pdn_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedge samples while state_o equals st.
    task automatic dwell(input int st, output int n);
        n = 0;
        while (int'(state_o) == st && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_state(input int st);
        for (int i = 0; i < 40 && int'(state_o) != st; i++) @(negedge clk);
    endtask

    task automatic go_active(input logic r, input logic s, input int exp, input string tag);
        int n;
        ramp_en = r; rate_low = s; sw_en = 1'b1;
        @(negedge clk);
        dwell(3, n);
        chk(tag, n, exp);
        chk(tag, int'(state_o), 4);
    endtask

    task automatic go_idle(input int exp, input string tag);
        int n;
        sw_en = 1'b0;
        @(negedge clk);
        dwell(5, n);
        chk(tag, n, exp);
        chk(tag, int'(state_o), 2);
        chk("R8 done set", int'(pdn_done), 1);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1 state", int'(state_o), 0);
        chk("R1 ready", int'(ctrl_ready), 0);
        chk("R1 active", int'(amp_active), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 state after release", int'(state_o), 0);
        chk("R1 pdn_done", int'(pdn_done), 0);
    endtask

    task automatic t_boot();
        int n;
        pad_rst_n = 1'b1;
        wait_state(1);
        chk("R11 not ready in init", int'(ctrl_ready), 0);
        dwell(1, n);
        chk("R3 boot dwell", n, 1500 * K);
        chk("R3 idle", int'(state_o), 2);
        chk("R11 ready idle", int'(ctrl_ready), 1);
    endtask

    task automatic t_modes();
        go_active(1'b0, 1'b0, 1000 * K, "R5 up fast");
        chk("R11 active flag", int'(amp_active), 1);
        chk("R11 ready active", int'(ctrl_ready), 1);
        go_idle(100 * K, "R6 down fast no ramp");
        go_active(1'b1, 1'b0, 2700 * K, "R5 up fast ramp");
        go_idle(4600 * K, "R6 down fast ramp");
        go_active(1'b0, 1'b1, 2300 * K, "R5 up slow");
        go_idle(100 * K, "R6 down slow no ramp");
        go_active(1'b1, 1'b1, 4200 * K, "R5 up slow ramp");
        go_idle(8000 * K, "R6 down slow ramp");
    endtask

    task automatic t_sample_hold();
        int n;
        ramp_en = 1'b0; rate_low = 1'b0; sw_en = 1'b1;
        @(negedge clk);
        chk("R8 done cleared on enable", int'(pdn_done), 0);
        ramp_en = 1'b1; rate_low = 1'b1;
        dwell(3, n);
        chk("R7 up mode held", n, 1000 * K);
        sw_en = 1'b0;
        @(negedge clk);
        ramp_en = 1'b0;
        dwell(5, n);
        chk("R7 down mode held", n, 8000 * K);
    endtask

    task automatic t_abort_and_hold();
        int n;
        ramp_en = 1'b1; rate_low = 1'b0; sw_en = 1'b1;
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R9 still up", int'(state_o), 3);
        sw_en = 1'b0;
        @(negedge clk);
        chk("R9 abort to down", int'(state_o), 5);
        sw_en = 1'b1;
        dwell(5, n);
        chk("R10 full down dwell", n, 4600 * K);
        chk("R10 back to idle", int'(state_o), 2);
        chk("R8 done after abort", int'(pdn_done), 1);
        @(negedge clk);
        chk("R10 then power-up", int'(state_o), 3);
        chk("R8 cleared by enable", int'(pdn_done), 0);
        sw_en = 1'b0;
        @(negedge clk);
        dwell(5, n);
        chk("R6 down after restart", n, 4600 * K);
    endtask

    task automatic t_swreset();
        int n;
        chk("R4 pre done", int'(pdn_done), 1);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        chk("R4 init", int'(state_o), 1);
        chk("R4 done cleared", int'(pdn_done), 0);
        chk("R11 not ready", int'(ctrl_ready), 0);
        dwell(1, n);
        chk("R4 swreset dwell", n, 400 * K);
        chk("R4 idle", int'(state_o), 2);
    endtask

    task automatic t_pin();
        int n;
        go_active(1'b0, 1'b0, 1000 * K, "R5 up for pin test");
        pad_rst_n = 1'b0;
        @(negedge clk);
        pad_rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 short pulse ignored", int'(state_o), 4);
        sw_en = 1'b0;
        pad_rst_n = 1'b0;
        repeat (K) @(negedge clk);
        pad_rst_n = 1'b1;
        wait_state(0);
        chk("R2 min pulse shuts down", int'(state_o), 0);
        chk("R11 off not ready", int'(ctrl_ready), 0);
        wait_state(1);
        dwell(1, n);
        chk("R3 reboot dwell", n, 1500 * K);
        chk("R3 idle after reboot", int'(state_o), 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_boot();
        t_modes();
        t_sample_hold();
        t_abort_and_hold();
        t_swreset();
        t_pin();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule